// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the core reset of a small microcontroller. A one-shot delay is started by any of five events: power becoming good, an accepted stop-mode wake request, or a watchdog expiry in run, halt or stop mode. The first stage of the delay counts ticks of a slow internal oscillator. That oscillator is not modelled here; the block sees it only as a one-cycle tick enable that is synchronous to the system clock. When the tick count runs out, reset is held for a fixed number of system clocks. Reset is then released and the program start address appears on the vector output.

The stop-mode wake pin is first synchronised. It then passes through a stability filter before it can start a sequence. A reset started only by the wake pin is marked warm, so that the port-mode and interrupt-priority registers outside this block keep their contents. Every other reset is cold, and those registers are reinitialised. A trigger that arrives during a sequence restarts the sequence from its first stage. Loss of power (`pwr_good` low) clears the block at once, without waiting for a clock, and holds the core in reset.

The controller has four states:
- ST_OFF: power is bad, or no trigger has been seen yet.
- ST_SLOW: counting oscillator ticks.
- ST_HOLD: counting system clocks.
- ST_RUN: reset is released.

Its transitions are:
- START: any trigger moves the controller to ST_SLOW from any state, which also restarts a sequence already in progress.
- SLOW_DONE: the last tick moves ST_SLOW to ST_HOLD.
- HOLD_DONE: the last hold clock moves ST_HOLD to ST_RUN.
- POWER_LOSS: `pwr_good` low forces ST_OFF asynchronously.

Top module: `rst_sequencer`

## Requirements
- R1: While `pwr_good` is low, `chip_reset` is 1, `warm_reset` is 0 and `reset_vector` is 0, with no clock needed.
- R2: A rising edge of `pwr_good`, seen through a two-flop synchroniser, starts a sequence. `chip_reset` stays 1 until DLY_TICKS cycles with `osc_tick` high have been sampled, however many clocks pass between ticks.
- R3: After the clock edge that samples the final tick, `chip_reset` stays 1 for exactly HOLD_CLKS (default 18) system clocks. It goes low on the HOLD_CLKS-th rising edge after that sampling edge.
- R4: While `chip_reset` is 0, `reset_vector` equals START_ADDR (default 16'h000C). While `chip_reset` is 1, `reset_vector` reads 0.
- R5: A one-clock high pulse on any of `wdt_run_to`, `wdt_halt_to` or `wdt_stop_to` sets `chip_reset` to 1 at the next clock edge and starts a cold sequence, with `warm_reset` 0.
- R6: `wake_pin` is synchronised with two flops. It is accepted only after FILT_CYC consecutive synchronised samples of 1. A shorter high pulse has no effect on `chip_reset`.
- R7: An accepted rising edge of the wake input starts a sequence with `warm_reset` 1. A falling edge of the wake input has no effect.
- R8: `warm_reset` keeps the value set by the latest trigger until the next trigger or until power is lost. When a wake event coincides with any other trigger, the sequence is cold.
- R9: A trigger that arrives during a sequence, in either stage, restarts it from the beginning. A full DLY_TICKS ticks are then needed again before the HOLD_CLKS stage.
- R10: `osc_tick` has no effect while reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Power-good level from the analog detector; low clears the block asynchronously |
| osc_tick | input | 1 | One-cycle enable marking each tick of the slow internal oscillator |
| wake_pin | input | 1 | Asynchronous stop-mode wake request, active high |
| wdt_run_to | input | 1 | Watchdog expiry pulse, run mode |
| wdt_halt_to | input | 1 | Watchdog expiry pulse, halt mode |
| wdt_stop_to | input | 1 | Watchdog expiry pulse, stop mode |
| chip_reset | output | 1 | Core reset, active high |
| reset_vector | output | 16 | Program start address while reset is released, else 0 |
| warm_reset | output | 1 | 1 when the latest reset came from stop-mode wake |

## Verification
The bench measures the length of the hold stage at clock resolution, so a design that is off by one in its counter is caught. It holds reset through long gaps with one tick still missing, which exposes a sequencer that releases on a clock count rather than on ticks. It sends a wake glitch one sample shorter than the filter window, which catches a filter that accepts too early. It then restarts a sequence from the hold stage and checks that a full tick count is required again, which catches a counter that is not cleared. It also checks that `warm_reset` survives the wake pin falling and release of reset, and that power loss or a watchdog reset clears it. A design that keeps stale warm state would spare registers that ought to be reinitialised.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SLOW = 2'd1,
        ST_HOLD = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rstseq_filter.sv
module rstseq_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          lvl;
    logic [CW-1:0] cnt;

    // Level changes only after FILT_CYC consecutive samples differ from it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl  <= 1'b0;
            cnt  <= '0;
            rise <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (d == lvl) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_CYC - 1)) begin
                lvl  <= d;
                cnt  <= '0;
                rise <= d;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int          DLY_TICKS  = 64,
    parameter int          HOLD_CLKS  = 18,
    parameter logic [15:0] START_ADDR = 16'h000C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig,
    input  logic        warm_src,
    input  logic        tick,
    output logic        chip_reset,
    output logic [15:0] reset_vector,
    output logic        warm_reset
);
    localparam int CMAX = (DLY_TICKS > HOLD_CLKS) ? DLY_TICKS : HOLD_CLKS;
    localparam int CW   = $clog2(CMAX + 1);

    seq_state_t    state, nxt;
    logic [CW-1:0] cnt;
    logic          warm_q;

    // Next-state decision: START overrides every state.
    always_comb begin
        nxt = state;
        if (trig) begin
            nxt = ST_SLOW;
        end else begin
            unique case (state)
                ST_OFF:  nxt = ST_OFF;
                ST_SLOW: if (tick && cnt == CW'(DLY_TICKS - 1)) nxt = ST_HOLD;
                ST_HOLD: if (cnt == CW'(HOLD_CLKS - 1))        nxt = ST_RUN;
                ST_RUN:  nxt = ST_RUN;
            endcase
        end
    end

    // State register with its stage counter and warm marker.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            cnt    <= '0;
            warm_q <= 1'b0;
        end else begin
            state <= nxt;
            if (trig)
                warm_q <= warm_src;
            if (trig || nxt != state)
                cnt <= '0;
            else if ((state == ST_SLOW && tick) || state == ST_HOLD)
                cnt <= cnt + 1'b1;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        chip_reset   = (state != ST_RUN);
        reset_vector = (state == ST_RUN) ? START_ADDR : 16'h0000;
        warm_reset   = warm_q;
    end
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
    parameter int          DLY_TICKS  = 64,
    parameter int          HOLD_CLKS  = 18,
    parameter int          FILT_CYC   = 4,
    parameter logic [15:0] START_ADDR = 16'h000C
) (
    input  logic        clk,
    input  logic        pwr_good,
    input  logic        osc_tick,
    input  logic        wake_pin,
    input  logic        wdt_run_to,
    input  logic        wdt_halt_to,
    input  logic        wdt_stop_to,
    output logic        chip_reset,
    output logic [15:0] reset_vector,
    output logic        warm_reset
);
    logic pg_sync, pg_d, pg_rise;
    logic wake_sync, wake_go;
    logic cold_trig, trig;

    rstseq_sync u_pg_sync (
        .clk   (clk),
        .rst_n (pwr_good),
        .d     (1'b1),
        .q     (pg_sync)
    );

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) pg_d <= 1'b0;
        else           pg_d <= pg_sync;
    end
    assign pg_rise = pg_sync & ~pg_d;

    rstseq_sync u_wake_sync (
        .clk   (clk),
        .rst_n (pwr_good),
        .d     (wake_pin),
        .q     (wake_sync)
    );

    rstseq_filter #(.FILT_CYC(FILT_CYC)) u_wake_filt (
        .clk   (clk),
        .rst_n (pwr_good),
        .d     (wake_sync),
        .rise  (wake_go)
    );

    assign cold_trig = pg_rise | wdt_run_to | wdt_halt_to | wdt_stop_to;
    assign trig      = cold_trig | wake_go;

    rstseq_fsm #(
        .DLY_TICKS  (DLY_TICKS),
        .HOLD_CLKS  (HOLD_CLKS),
        .START_ADDR (START_ADDR)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (pwr_good),
        .trig         (trig),
        .warm_src     (wake_go & ~cold_trig),
        .tick         (osc_tick),
        .chip_reset   (chip_reset),
        .reset_vector (reset_vector),
        .warm_reset   (warm_reset)
    );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter logic [15:0] START_ADDR = 16'h000C
) (
    input logic        clk,
    input logic        pwr_good,
    input logic        wdt_run_to,
    input logic        wdt_halt_to,
    input logic        wdt_stop_to,
    input logic        pg_rise,
    input logic        wake_go,
    input logic        chip_reset,
    input logic [15:0] reset_vector,
    input logic        warm_reset
);
    logic wdt_any, any_trig;
    assign wdt_any  = wdt_run_to | wdt_halt_to | wdt_stop_to;
    assign any_trig = wdt_any | pg_rise | wake_go;

    // R4
    vector_run_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !chip_reset |-> reset_vector == START_ADDR);
    // R4
    vector_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        chip_reset |-> reset_vector == 16'h0000);
    // R5
    wdt_trig_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        wdt_any |=> chip_reset && !warm_reset);
    // R7
    wake_warm_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (wake_go && !wdt_any && !pg_rise) |=> chip_reset && warm_reset);
    // R10
    tick_ignored_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (!chip_reset && !any_trig) |=> !chip_reset);
    // R8
    warm_stable_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !any_trig |=> $stable(warm_reset));
endmodule

bind rst_sequencer rstseq_chk #(.START_ADDR(START_ADDR)) u_chk (.*);

// File: tb/rst_sequencer_bench.sv
`timescale 1ns/1ps
module rst_sequencer_bench;
    localparam int          DLY  = 4;
    localparam int          HOLD = 18;
    localparam int          FILT = 4;
    localparam logic [15:0] VEC  = 16'h000C;

    logic        clk = 1'b0;
    logic        pwr_good = 1'b0, osc_tick = 1'b0, wake_pin = 1'b0;
    logic        wdt_run_to = 1'b0, wdt_halt_to = 1'b0, wdt_stop_to = 1'b0;
    logic        chip_reset, warm_reset;
    logic [15:0] reset_vector;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    rst_sequencer #(.DLY_TICKS(DLY), .HOLD_CLKS(HOLD), .FILT_CYC(FILT), .START_ADDR(VEC))
    u_rst_sequencer (.*);

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
            idle(3);
        end
    endtask

    // Gives the last tick and measures how long reset stays high afterwards.
    task automatic finish_seq(input string req, input logic warm_exp);
        int n = 0;
        ticks(DLY - 1);
        idle(30);
        chk(chip_reset === 1'b1, "R2 held short of ticks", chip_reset, 1);
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
        chk(reset_vector === 16'h0, "R4 vector zero in hold", reset_vector, 0);
        while (chip_reset === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == HOLD, {req, " R3 hold length"}, n, HOLD);
        chk(reset_vector === VEC, "R4 start address", reset_vector, VEC);
        chk(warm_reset === warm_exp, "R8 warm flag after release", warm_reset, warm_exp);
    endtask

    task automatic t_reset_state();
        #1;
        chk(chip_reset === 1'b1 && warm_reset === 1'b0 && reset_vector === 16'h0,
            "R1 power bad state", chip_reset, 1);
    endtask

    task automatic t_power_up();
        @(negedge clk) pwr_good = 1'b1;
        idle(6);
        finish_seq("R2", 1'b0);
    endtask

    task automatic t_watchdog(input int which);
        @(negedge clk);
        case (which)
            0: wdt_run_to = 1'b1;
            1: wdt_halt_to = 1'b1;
            default: wdt_stop_to = 1'b1;
        endcase
        @(negedge clk) {wdt_run_to, wdt_halt_to, wdt_stop_to} = 3'b000;
        chk(chip_reset === 1'b1 && warm_reset === 1'b0, "R5 watchdog trigger", chip_reset, 1);
        finish_seq("R5", 1'b0);
    endtask

    task automatic t_wake();
        @(negedge clk) wake_pin = 1'b1;
        idle(FILT - 1);
        wake_pin = 1'b0;
        idle(12);
        chk(chip_reset === 1'b0, "R6 short wake ignored", chip_reset, 0);
        wake_pin = 1'b1;
        idle(10);
        chk(chip_reset === 1'b1 && warm_reset === 1'b1, "R7 wake warm reset", warm_reset, 1);
        finish_seq("R7", 1'b1);
        wake_pin = 1'b0;
        idle(12);
        chk(chip_reset === 1'b0 && warm_reset === 1'b1, "R7 wake fall ignored", chip_reset, 0);
    endtask

    task automatic t_restart();
        @(negedge clk) wdt_run_to = 1'b1;
        @(negedge clk) wdt_run_to = 1'b0;
        chk(warm_reset === 1'b0, "R8 watchdog clears warm", warm_reset, 0);
        ticks(DLY);
        idle(5);
        @(negedge clk) wdt_halt_to = 1'b1;
        @(negedge clk) wdt_halt_to = 1'b0;
        idle(60);
        chk(chip_reset === 1'b1, "R9 restart needs ticks", chip_reset, 1);
        finish_seq("R9", 1'b0);
    endtask

    task automatic t_tick_idle();
        ticks(DLY + 2);
        chk(chip_reset === 1'b0, "R10 ticks ignored when running", chip_reset, 0);
    endtask

    task automatic t_power_loss();
        @(negedge clk) wake_pin = 1'b1;
        idle(12);
        finish_seq("R7", 1'b1);
        #1 pwr_good = 1'b0;
        #1;
        chk(chip_reset === 1'b1 && warm_reset === 1'b0, "R1 power loss clears", warm_reset, 0);
        wake_pin = 1'b0;
        @(negedge clk) pwr_good = 1'b1;
        idle(6);
        finish_seq("R2", 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_power_up();
        t_watchdog(0);
        t_watchdog(1);
        t_watchdog(2);
        t_wake();
        t_restart();
        t_tick_idle();
        t_power_loss();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule